// File: doc/BRIEF.md
# Peak-Sampling Maximum Power Point PWM Controller

This block drives the switch gate of a boost-type solar charger. It runs a fixed-period PWM whose high time is a tracked on-time. Once per evaluation it sends a one-clock start pulse to an external ADC. The pulse is placed a programmable number of clocks before the gate falls, so the conversion aperture closes at turn-off. At that point the inductor current is at its peak. The voltage across the switch at that instant is the only tracking metric. The output voltage is treated as constant, so a larger peak sample means more delivered power. Only relative size matters, so no scaling is applied.

After every on-time change the controller waits a programmable number of whole PWM periods. This lets the input capacitor and the inductor settle, on the order of the square root of LC. It then samples again and compares the new result with the stored one. It steps the on-time up or down in hill-climb fashion, clamped to a programmable window. With a 50 MHz clock, a period count of 1000 gives a 20 us cycle. An on-time count near 400 is a typical operating point.

Top module: `mppt_pwm_ctrl`

## Requirements
- R1: The counter runs from 0 to `period`-1 and repeats. `gate` is high on the first `ton` counts of every period, where `ton` is the on-time on the port.
- R2: `adc_start` is exactly one clock wide. It fires `lead` clocks before the falling edge of `gate` (at count `ton`-`lead`), and only in a sample period.
- R3: The on-time changes only at a period boundary, the clock in which the counter returns to 0. Between decisions it holds its value.
- R4: After an on-time change, `settle_periods`+1 complete periods pass at the new on-time before the sample. The sample is taken in the period after them, the (`settle_periods`+2)-th period counting from the change.
- R5: If the new sample is below the stored one, the step direction reverses. If it is equal or higher, the direction is kept. Each step moves the on-time by `ton_step`.
- R6: A step up never goes past `ton_max`, and a step down never goes below `ton_min`. At a limit the on-time sits on that limit.
- R7: Samples compare as unsigned codes. A full-scale result (all ones) is the largest possible value and never wraps.
- R8: While `rst` is high, `gate` and `adc_start` are low and `ton` equals `period`/2, rounded down. The first decision after reset has no stored sample and steps upward.
- R9: When `en` is low, `gate` is low from the next clock on. The on-time returns to `period`/2, the stored sample is cleared and the direction returns to upward.
- R10: If `adc_ready` does not arrive within `TMO_CYC` clocks of the start pulse, that decision is skipped. The on-time is unchanged, and a new settling interval and sample follow.
- R11: An `adc_ready` strobe that arrives when no conversion is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Synchronous run enable; low holds the gate off and clears tracking state |
| period | input | CNT_W | PWM period in clocks (at least 2) |
| ton_min | input | CNT_W | Lower on-time limit |
| ton_max | input | CNT_W | Upper on-time limit |
| ton_step | input | CNT_W | On-time change per decision |
| lead | input | CNT_W | Clocks from ADC start to gate turn-off |
| settle_periods | input | SET_W | Extra whole periods waited after a change |
| adc_data | input | ADC_W | Conversion result, unsigned |
| adc_ready | input | 1 | One-clock strobe: `adc_data` is valid |
| gate | output | 1 | Switch gate drive |
| adc_start | output | 1 | One-clock conversion start pulse |
| ton | output | CNT_W | Current on-time in clocks |

## Verification
The hardest states to reach are the on-time limits and a full-scale sample. At these, a wrong clamp or a signed compare only shows after several correct decisions in a row. The bench feeds rising or equal samples to drive the on-time into `ton_max`, then falling and equal samples to walk it down to `ton_min`. It then places all-ones codes on both sides of a comparison. A conversion that never answers, and a stray ready strobe during settling, are produced by withholding or misplacing `adc_ready` relative to the observed start pulse.

// File: rtl/mppt_pkg.sv
package mppt_pkg;
    typedef enum logic [1:0] {
        TRK_SETTLE,
        TRK_ARM,
        TRK_WAIT,
        TRK_APPLY
    } trk_state_e;
endpackage

// File: rtl/mppt_pwm_timer.sv
module mppt_pwm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] ton,
    input  logic [CNT_W-1:0] lead,
    input  logic             arm,
    output logic             gate,
    output logic             start,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] start_pos;

    always_comb begin
        last_cnt  = period - CNT_W'(1);
        start_pos = (lead >= ton) ? '0 : (ton - lead);
        wrap      = q.run && (q.cnt >= last_cnt);
        gate      = q.run && (q.cnt < ton);
        start     = q.run && arm && (q.cnt == start_pos);
        cnt       = q.cnt;

        d = q;
        if (rst || !en) begin
            d = '0;
        end else begin
            d.run = 1'b1;
            if (!q.run || wrap) d.cnt = '0;
            else                d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    // R2: the start pulse never lasts two clocks
    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R2: the start pulse lies inside the high phase, before turn-off
    a_r2_start_in_on: assert property (@(posedge clk) disable iff (rst)
        (start && lead != '0 && lead < ton) |-> gate);

    // R9: gate is off the clock after enable drops
    a_r9_gate_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gate);
endmodule

// File: rtl/mppt_hill_step.sv
module mppt_hill_step #(
    parameter int CNT_W = 16,
    parameter int ADC_W = 12
) (
    input  logic [CNT_W-1:0] ton,
    input  logic [CNT_W-1:0] step,
    input  logic [CNT_W-1:0] ton_min,
    input  logic [CNT_W-1:0] ton_max,
    input  logic             dir_up,
    input  logic             have_prev,
    input  logic [ADC_W-1:0] prev,
    input  logic [ADC_W-1:0] sample,
    output logic [CNT_W-1:0] ton_nx,
    output logic             dir_nx
);
    logic [CNT_W:0] raised;
    logic [CNT_W:0] floor_lim;

    always_comb begin
        dir_nx    = (have_prev && (sample < prev)) ? !dir_up : dir_up;
        raised    = {1'b0, ton} + {1'b0, step};
        floor_lim = {1'b0, ton_min} + {1'b0, step};
        if (dir_nx) begin
            ton_nx = (raised > {1'b0, ton_max}) ? ton_max : raised[CNT_W-1:0];
        end else begin
            ton_nx = ({1'b0, ton} < floor_lim) ? ton_min : (ton - step);
        end
    end
endmodule

// File: rtl/mppt_tracker.sv
module mppt_tracker
    import mppt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int ADC_W   = 12,
    parameter int SET_W   = 8,
    parameter int TMO_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] ton_min,
    input  logic [CNT_W-1:0] ton_max,
    input  logic [CNT_W-1:0] ton_step,
    input  logic [SET_W-1:0] settle_periods,
    input  logic [ADC_W-1:0] adc_data,
    input  logic             adc_ready,
    input  logic             wrap,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ton,
    output logic             arm
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);

    typedef struct packed {
        trk_state_e       st;
        logic [CNT_W-1:0] ton;
        logic [CNT_W-1:0] pend;
        logic             dir_up;
        logic             have_prev;
        logic [ADC_W-1:0] prev;
        logic [SET_W-1:0] settle;
        logic [TMO_W-1:0] tmo;
    } trk_t;

    trk_t d, q;
    logic [CNT_W-1:0] step_ton;
    logic             step_dir;

    mppt_hill_step #(.CNT_W(CNT_W), .ADC_W(ADC_W)) u_step (
        .ton       (q.ton),
        .step      (ton_step),
        .ton_min   (ton_min),
        .ton_max   (ton_max),
        .dir_up    (q.dir_up),
        .have_prev (q.have_prev),
        .prev      (q.prev),
        .sample    (adc_data),
        .ton_nx    (step_ton),
        .dir_nx    (step_dir)
    );

    always_comb begin
        d = q;
        if (rst || !en) begin
            d           = '0;
            d.st        = TRK_SETTLE;
            d.ton       = period >> 1;
            d.pend      = period >> 1;
            d.dir_up    = 1'b1;
        end else begin
            unique case (q.st)
                TRK_SETTLE: if (wrap) begin
                    if (q.settle >= settle_periods) begin
                        d.st     = TRK_ARM;
                        d.settle = '0;
                    end else begin
                        d.settle = q.settle + SET_W'(1);
                    end
                end
                TRK_ARM: if (start) begin
                    d.st  = TRK_WAIT;
                    d.tmo = '0;
                end
                TRK_WAIT: begin
                    if (adc_ready) begin
                        d.prev      = adc_data;
                        d.have_prev = 1'b1;
                        d.dir_up    = step_dir;
                        d.pend      = step_ton;
                        d.st        = TRK_APPLY;
                    end else if (q.tmo == TMO_W'(TMO_CYC - 1)) begin
                        d.st     = TRK_SETTLE;
                        d.settle = '0;
                    end else begin
                        d.tmo = q.tmo + TMO_W'(1);
                    end
                end
                TRK_APPLY: if (wrap) begin
                    d.ton    = q.pend;
                    d.settle = '0;
                    d.st     = TRK_SETTLE;
                end
                default: d.st = TRK_SETTLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign ton = q.ton;
    assign arm = (q.st == TRK_ARM);

    // R3: on-time moves only where the timer restarts its count
    a_r3_change_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(q.ton)) |-> (cnt == '0));

    // R6: a decided on-time lies inside the window
    a_r6_ton_in_window: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(q.ton)) |-> (q.ton >= ton_min && q.ton <= ton_max));

    // R5: from inside the window a change never exceeds one step
    a_r5_step_size: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(q.ton) && $past(q.ton) >= ton_min && $past(q.ton) <= ton_max)
        |-> (((q.ton >= $past(q.ton)) ? (q.ton - $past(q.ton)) : ($past(q.ton) - q.ton)) <= ton_step));

    // R10: the wait for a result is bounded
    a_r10_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        (q.st == TRK_WAIT) |-> (q.tmo < TMO_W'(TMO_CYC)));
endmodule

// File: rtl/mppt_pwm_ctrl.sv
module mppt_pwm_ctrl #(
    parameter int CNT_W   = 16,
    parameter int ADC_W   = 12,
    parameter int SET_W   = 8,
    parameter int TMO_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] ton_min,
    input  logic [CNT_W-1:0] ton_max,
    input  logic [CNT_W-1:0] ton_step,
    input  logic [CNT_W-1:0] lead,
    input  logic [SET_W-1:0] settle_periods,
    input  logic [ADC_W-1:0] adc_data,
    input  logic             adc_ready,
    output logic             gate,
    output logic             adc_start,
    output logic [CNT_W-1:0] ton
);
    logic             wrap;
    logic             arm;
    logic [CNT_W-1:0] cnt;

    mppt_pwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .period (period),
        .ton    (ton),
        .lead   (lead),
        .arm    (arm),
        .gate   (gate),
        .start  (adc_start),
        .wrap   (wrap),
        .cnt    (cnt)
    );

    mppt_tracker #(
        .CNT_W   (CNT_W),
        .ADC_W   (ADC_W),
        .SET_W   (SET_W),
        .TMO_CYC (TMO_CYC)
    ) u_tracker (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .period         (period),
        .ton_min        (ton_min),
        .ton_max        (ton_max),
        .ton_step       (ton_step),
        .settle_periods (settle_periods),
        .adc_data       (adc_data),
        .adc_ready      (adc_ready),
        .wrap           (wrap),
        .start          (adc_start),
        .cnt            (cnt),
        .ton            (ton),
        .arm            (arm)
    );

    // R8: nothing switches while reset is held
    a_r8_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!gate && !adc_start));
endmodule

// File: tb/mppt_pwm_ctrl_bench.sv
module mppt_pwm_ctrl_bench;
    localparam int P   = 40;
    localparam int LD  = 5;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [15:0] period, ton_min, ton_max, ton_step, lead;
    logic [7:0]  settle_periods;
    logic [11:0] adc_data;
    logic        adc_ready;
    logic        gate, adc_start;
    logic [15:0] ton;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    bit gl   = 0;
    bit rise = 0;

    int m_ton, m_prev;
    bit m_dir, m_have;

    always #5 clk = ~clk;

    mppt_pwm_ctrl #(.TMO_CYC(TMO)) u_mppt_pwm_ctrl (
        .clk(clk), .rst(rst), .en(en), .period(period),
        .ton_min(ton_min), .ton_max(ton_max), .ton_step(ton_step),
        .lead(lead), .settle_periods(settle_periods),
        .adc_data(adc_data), .adc_ready(adc_ready),
        .gate(gate), .adc_start(adc_start), .ton(ton)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        rise = gate && !gl;
        gl   = gate;
    endtask

    function automatic void model_reset();
        m_ton = P / 2; m_dir = 1; m_have = 0; m_prev = 0;
    endfunction

    function automatic void model_step(input int smp);
        if (m_have && smp < m_prev) m_dir = !m_dir;
        if (m_dir) m_ton = (m_ton + int'(ton_step) > int'(ton_max)) ? int'(ton_max) : m_ton + int'(ton_step);
        else       m_ton = (m_ton < int'(ton_min) + int'(ton_step)) ? int'(ton_min) : m_ton - int'(ton_step);
        m_prev = smp; m_have = 1;
    endfunction

    task automatic wait_start();
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (adc_start) return;
        end
        chk("R4 start pulse missing", 0, 1);
    endtask

    // Called on a clock where adc_start is high; returns on the next one.
    task automatic eval(input int smp, input string req, input bit no_reply, input bit stale);
        int k, h, rises;
        chk("R3 on-time held before decision", int'(ton), m_ton);
        k = 0;
        while (gate && k < 1000) begin tick(); k++; end
        chk("R2 start lead to turn-off", k, LD);
        if (no_reply) begin
            for (int i = 0; i < 3000; i++) begin
                tick(); k++;
                if (adc_start) break;
            end
            chk("R10 on-time kept after timeout", int'(ton), m_ton);
            chk("R10 retry after timeout window", int'(k >= TMO), 1);
            return;
        end
        adc_data = 12'(smp); adc_ready = 1'b1;
        tick();
        adc_ready = 1'b0;
        model_step(smp);
        for (int i = 0; i < 200; i++) begin
            if (rise) break;
            tick();
        end
        chk(req, int'(ton), m_ton);
        if (stale) begin
            adc_data = 12'd0; adc_ready = 1'b1;
            tick();
            adc_ready = 1'b0;
        end else begin
            h = 1;
            for (int i = 0; i < 200; i++) begin
                tick();
                if (!gate) break;
                h++;
            end
            chk("R1 gate high count", h, m_ton);
        end
        rises = 1;
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (rise) rises++;
            if (adc_start) break;
        end
        chk("R4 settle periods before sample", rises, int'(settle_periods) + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R10 watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; en = 1; period = 16'(P); ton_min = 16'd8; ton_max = 16'd24;
        ton_step = 16'd3; lead = 16'(LD); settle_periods = 8'd1;
        adc_data = '0; adc_ready = 0;
        repeat (3) tick();
        chk("R8 gate low in reset", int'(gate), 0);
        chk("R8 no start in reset", int'(adc_start), 0);
        chk("R8 reset on-time", int'(ton), P / 2);
        model_reset();
        rst = 0;
        wait_start();
        eval(100, "R8 first step upward", 0, 0);
        eval(200, "R6 clamp at max", 0, 0);
        eval(300, "R6 hold at max", 0, 0);
        eval(250, "R5 reverse on drop", 0, 0);
        eval(250, "R5 keep on equal", 0, 0);
        settle_periods = 8'd0;
        eval(260, "R5 keep on rise", 0, 0);
        eval(270, "R5 down step", 0, 0);
        eval(280, "R5 down step", 0, 0);
        eval(290, "R6 clamp at min", 0, 0);
        eval(300, "R6 hold at min", 0, 0);
        eval(4095, "R7 full scale keeps direction", 0, 0);
        eval(4094, "R7 below full scale reverses", 0, 1);
        eval(4094, "R11 stale ready ignored", 0, 0);
        eval(0, "R10 timeout", 1, 0);
        eval(4094, "R10 after timeout keeps prev", 0, 0);
        en = 0;
        tick();
        tick();
        chk("R9 gate low when disabled", int'(gate), 0);
        chk("R9 on-time back to half", int'(ton), P / 2);
        repeat (5) tick();
        en = 1;
        model_reset();
        wait_start();
        eval(0, "R9 prev cleared steps up", 0, 0);
        ton_max = 16'd30;
        for (int n = 0; n < 40; n++) begin
            int smp;
            settle_periods = 8'($urandom_range(3, 0));
            smp = ($urandom_range(3, 0) == 0) ? m_prev : int'($urandom_range(4095, 0));
            eval(smp, "R5 random decision", 0, 0);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule